// File: doc/BRIEF.md
# Read-Acquire Channel Lock Bank

This block holds one lock per auxiliary channel. Each lock decides whether the channel belongs to the host software or to an autonomous hardware agent at any moment. The host reaches each lock through a single-cycle register port. While a lock is enabled, a host read is also a claim. The status bit in the returned word tells the host whether the claim succeeded: 0 means the host now owns the channel, and 1 means some other party already holds it. The host gives the lock back by writing the word with the status bit set.

The hardware agent uses a level request and a one-cycle release pulse. It receives a registered grant that gates its use of the channel. The agent competes for the lock only while the enable bit is set. For this reason software is expected to set the enable bit once and leave it set. The host can retry a refused claim by reading again, and it decides on its own how long to keep trying.

Each channel's lock sits at byte offset 0x2C inside its own 0x100-byte window. Channel c answers at address c*0x100 + 0x2C.

Top module: `aux_mtx_bank`

## Requirements
- R1: After reset every lock is disabled and free. Every read word is 0, and no grant or host-owner flag is high.
- R2: Bit 31 of the lock word reads back the enable bit and bit 30 is the status bit. Bits 29:0 always read 0, and writing them changes nothing.
- R3: A host read of an enabled, free lock, with no agent request in that cycle, returns status 0. The host-owner flag is high from the next cycle on, and later reads return status 1.
- R4: A host read of a lock that is already held returns status 1 and leaves the owner and its flag unchanged.
- R5: A host read of a disabled lock claims nothing and returns the current status.
- R6: Every write to a lock loads bit 31 into the enable bit. A write with bit 30 set frees a lock that the host owns.
- R7: A host release write has no effect while the agent owns the lock.
- R8: An agent request on an enabled, free lock raises the grant in the next cycle. The grant stays high until the agent's release pulse.
- R9: Agent requests are ignored while the lock is disabled, so the grant stays low.
- R10: When a host read and an agent request reach a free, enabled lock in the same cycle, the agent wins and the read returns status 1.
- R11: A read returns the read data one cycle after it is issued. Addresses other than c*0x100+0x2C for c below the channel count read 0 and claim nothing. The locks are independent of each other.
- R12: An agent that is waiting while the host owns the lock receives the grant one cycle after the host's release write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte address |
| host_rd | input | 1 | Host read strobe; on an enabled lock it is also a claim |
| host_wr | input | 1 | Host write strobe (never together with host_rd) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read word, registered, valid the cycle after host_rd |
| agent_req | input | NUM_CH | Agent lock request, level, one per channel |
| agent_rel | input | NUM_CH | Agent release pulse, one per channel |
| agent_grant | output | NUM_CH | Registered grant: the agent owns the channel |
| host_owns | output | NUM_CH | The host owns the channel |

## Verification
A host claim read and an agent request can reach the same free lock in the same clock cycle. The bench provokes this by raising the agent request on the same falling edge on which it drives the read strobe. It then judges the outcome three ways: the queued read word must carry status 1, the grant must be high, and the host-owner flag must stay low. A second collision is also exercised: a host release write against a lock that the agent owns, which must leave the grant standing.

// File: rtl/aux_mtx_pkg.sv
package aux_mtx_pkg;

    localparam int WORD_W = 32;
    localparam int EN_POS = 31;
    localparam int ST_POS = 30;

    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_HOST  = 2'd1,
        OWN_AGENT = 2'd2
    } owner_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic wr_en;
        logic wr_rel;
    } host_op_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic en, input logic st);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_POS] = en;
        w[ST_POS] = st;
        return w;
    endfunction

endpackage

// File: rtl/aux_mtx_decode.sv
module aux_mtx_decode
    import aux_mtx_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int ADDR_W    = 12,
    parameter int WIN_SHIFT = 8,
    parameter int LOCK_OFS  = 'h2C
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       rd,
    input  logic                       wr,
    input  logic [WORD_W-1:0]          wdata,
    output logic [NUM_CH-1:0]          hit,
    output host_op_t [NUM_CH-1:0]      ops
);
    localparam int CH_AW = ADDR_W - WIN_SHIFT;

    logic ofs_match;
    assign ofs_match = (addr[WIN_SHIFT-1:0] == WIN_SHIFT'(LOCK_OFS));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c]       = ofs_match && (addr[ADDR_W-1:WIN_SHIFT] == CH_AW'(c));
        assign ops[c].rd     = rd && hit[c];
        assign ops[c].wr     = wr && hit[c];
        assign ops[c].wr_en  = wdata[EN_POS];
        assign ops[c].wr_rel = wdata[ST_POS];
    end
endmodule

// File: rtl/aux_mtx_cell.sv
module aux_mtx_cell
    import aux_mtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_op_t op,
    input  logic     agent_req,
    input  logic     agent_rel,
    output logic     en,
    output logic     rd_status,
    output logic     grant,
    output logic     host_own
);
    owner_e own_q, own_d;
    logic   en_q;
    logic   free;
    logic   agent_try;
    logic   host_try;

    assign free      = (own_q == OWN_FREE);
    assign agent_try = en_q && agent_req && free;
    assign host_try  = en_q && op.rd && free && !agent_req;

    always_comb begin
        own_d = own_q;
        unique case (own_q)
            OWN_FREE: begin
                if (agent_try)     own_d = OWN_AGENT;
                else if (host_try) own_d = OWN_HOST;
            end
            OWN_HOST:  if (op.wr && op.wr_rel) own_d = OWN_FREE;
            OWN_AGENT: if (agent_rel)          own_d = OWN_FREE;
            default:   own_d = OWN_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= OWN_FREE;
            en_q  <= 1'b0;
        end else begin
            own_q <= own_d;
            if (op.wr) en_q <= op.wr_en;
        end
    end

    assign en        = en_q;
    assign rd_status = !free || agent_try;
    assign grant     = (own_q == OWN_AGENT);
    assign host_own  = (own_q == OWN_HOST);

    // R3: enabled free lock, lone read -> host owns next cycle
    assert_host_claim_R3: assert property (@(posedge clk) disable iff (rst)
        (en_q && free && op.rd && !agent_req) |=> host_own);

    // R4: read on a host-held lock changes nothing
    assert_busy_read_R4: assert property (@(posedge clk) disable iff (rst)
        (op.rd && host_own) |=> host_own);

    // R7: host release cannot drop the agent's grant
    assert_foreign_release_R7: assert property (@(posedge clk) disable iff (rst)
        (grant && op.wr && op.wr_rel && !agent_rel) |=> grant);

    // R9: disabled free lock stays unowned
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!en_q && free) |=> (!grant && !host_own));

    // R10: tie goes to the agent
    assert_agent_tie_R10: assert property (@(posedge clk) disable iff (rst)
        (en_q && free && agent_req && op.rd) |=> (grant && !host_own));
endmodule

// File: rtl/aux_mtx_rdmux.sv
module aux_mtx_rdmux
    import aux_mtx_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] en_v,
    input  logic [NUM_CH-1:0] st_v,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) word_d = word_d | pack_word(en_v[c], st_v[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= word_d;
    end

    // R2: reserved field of the returned word is always zero
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rdata[ST_POS-1:0] == '0);
endmodule

// File: rtl/aux_mtx_bank.sv
module aux_mtx_bank
    import aux_mtx_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int ADDR_W    = 12,
    parameter int WIN_SHIFT = 8,
    parameter int LOCK_OFS  = 'h2C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [NUM_CH-1:0] agent_req,
    input  logic [NUM_CH-1:0] agent_rel,
    output logic [NUM_CH-1:0] agent_grant,
    output logic [NUM_CH-1:0] host_owns
);
    logic [NUM_CH-1:0]     hit;
    host_op_t [NUM_CH-1:0] ops;
    logic [NUM_CH-1:0]     en_v;
    logic [NUM_CH-1:0]     st_v;

    aux_mtx_decode #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .LOCK_OFS(LOCK_OFS)
    ) u_decode (
        .addr(host_addr), .rd(host_rd), .wr(host_wr), .wdata(host_wdata),
        .hit(hit), .ops(ops)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lock
        aux_mtx_cell u_cell (
            .clk(clk), .rst(rst), .op(ops[c]),
            .agent_req(agent_req[c]), .agent_rel(agent_rel[c]),
            .en(en_v[c]), .rd_status(st_v[c]),
            .grant(agent_grant[c]), .host_own(host_owns[c])
        );
    end

    aux_mtx_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .clk(clk), .rst(rst), .rd(host_rd), .hit(hit),
        .en_v(en_v), .st_v(st_v), .rdata(host_rdata)
    );
endmodule

// File: tb/aux_mtx_bank_tb_top.sv
module aux_mtx_bank_tb_top;
    localparam int NCH = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [11:0]    addr  = '0;
    logic           rd    = 1'b0;
    logic           wr    = 1'b0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] areq  = '0;
    logic [NCH-1:0] arel  = '0;
    logic [NCH-1:0] grant;
    logic [NCH-1:0] hown;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] word;
        string       tag;
    } exp_t;
    exp_t expq[$];
    logic rd_pend = 1'b0;

    aux_mtx_bank dut_i (
        .clk(clk), .rst(rst), .host_addr(addr), .host_rd(rd), .host_wr(wr),
        .host_wdata(wdata), .host_rdata(rdata), .agent_req(areq), .agent_rel(arel),
        .agent_grant(grant), .host_owns(hown)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: pops one expected word for every read the design served
    always @(posedge clk) rd_pend <= rd;
    always @(negedge clk) begin
        if (rd_pend) begin
            exp_t e;
            if (expq.size() == 0) begin
                check(1'b0, "R11 unexpected read", rdata, 32'h0);
            end else begin
                e = expq.pop_front();
                check(rdata === e.word, e.tag, rdata, e.word);
            end
        end
    end

    task automatic host_rd(input logic [11:0] a, input logic [31:0] expv, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; rd = 1'b1;
        e.word = expv; e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic chk_own(input int ch, input logic g, input logic h, input string tag);
        check({grant[ch], hown[ch]} === {g, h}, tag, 32'({grant[ch], hown[ch]}), 32'({g, h}));
    endtask

    localparam logic [11:0] A0 = 12'h02C;
    localparam logic [11:0] A1 = 12'h12C;
    localparam logic [11:0] A3 = 12'h32C;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(grant === '0 && hown === '0, "R1 no owner after reset", 32'({grant, hown}), 32'h0);
        host_rd(A0, 32'h0000_0000, "R1 reset word");
        chk_own(0, 1'b0, 1'b0, "R5 disabled read claims nothing");

        // R3/R4: enable then claim
        host_wr(A0, 32'h8000_0000);
        host_rd(A0, 32'h8000_0000, "R3 claim returns status 0");
        chk_own(0, 1'b0, 1'b1, "R3 host owns after claim");
        host_rd(A0, 32'hC000_0000, "R4 held read returns status 1");
        chk_own(0, 1'b0, 1'b1, "R4 owner unchanged");

        // R12: agent waits, then gets the lock after release
        @(negedge clk); areq[0] = 1'b1;
        @(negedge clk);
        chk_own(0, 1'b0, 1'b1, "R12 agent waits while host owns");
        host_wr(A0, 32'hC000_0000);
        chk_own(0, 1'b0, 1'b0, "R6 host release frees lock");
        @(negedge clk);
        chk_own(0, 1'b1, 1'b0, "R12 agent granted after release");

        // R7/R8: agent owns; host read and release leave it
        host_rd(A0, 32'hC000_0000, "R4 read while agent owns");
        host_wr(A0, 32'hC000_0000);
        chk_own(0, 1'b1, 1'b0, "R7 host release ignored for agent");
        @(negedge clk); areq[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk_own(0, 1'b1, 1'b0, "R8 grant held until release pulse");
        arel[0] = 1'b1;
        @(negedge clk); arel[0] = 1'b0;
        chk_own(0, 1'b0, 1'b0, "R8 grant drops after release pulse");

        // R10: same-cycle tie
        begin
            exp_t e;
            @(negedge clk);
            areq[0] = 1'b1; addr = A0; rd = 1'b1;
            e.word = 32'hC000_0000; e.tag = "R10 tie read returns status 1";
            expq.push_back(e);
            @(negedge clk);
            rd = 1'b0;
        end
        chk_own(0, 1'b1, 1'b0, "R10 agent wins tie");
        areq[0] = 1'b0; arel[0] = 1'b1;
        @(negedge clk); arel[0] = 1'b0;

        // R9: disabled channel ignores the agent
        @(negedge clk); areq[1] = 1'b1;
        repeat (2) @(negedge clk);
        chk_own(1, 1'b0, 1'b0, "R9 agent ignored while disabled");
        areq[1] = 1'b0;

        // R2: reserved bits
        host_wr(A3, 32'h3FFF_FFFF);
        host_rd(A3, 32'h0000_0000, "R2 reserved bits read zero");
        host_wr(A3, 32'hBFFF_FFFF);
        host_rd(A3, 32'h8000_0000, "R2 enable via write with reserved ones");
        chk_own(3, 1'b0, 1'b1, "R11 channel 3 host owned");
        chk_own(0, 1'b0, 1'b0, "R11 channel 0 independent");

        // R6: release then disable while free reads zero
        host_wr(A3, 32'hC000_0000);
        host_wr(A3, 32'h0000_0000);
        host_rd(A3, 32'h0000_0000, "R6 disabled free lock reads zero");

        // R5: disabled but held lock returns status 1 without change
        host_wr(A1, 32'h8000_0000);
        host_rd(A1, 32'h8000_0000, "R3 claim channel 1");
        host_wr(A1, 32'h0000_0000);
        host_rd(A1, 32'h4000_0000, "R5 disabled read reports held status");
        chk_own(1, 1'b0, 1'b1, "R5 owner kept while disabled");

        // R11: unmapped addresses
        host_wr(A0, 32'h8000_0000);
        host_rd(12'h02D, 32'h0000_0000, "R11 wrong offset reads zero");
        host_rd(12'h52C, 32'h0000_0000, "R11 missing channel reads zero");
        chk_own(0, 1'b0, 1'b0, "R11 unmapped read claims nothing");

        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R11 all reads answered", 32'(expq.size()), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule